// File: doc/BRIEF.md
# Flash Program/Erase Command Sequencer

This block sits on the host side of a parallel NOR flash. It takes one high-level request at a time: program a word, erase a sector, erase a block, erase the whole chip, or read the identification words. It turns that request into the unlock and command write cycles the flash expects, and drives them on a simple synchronous bus master port. After the final write it polls the target location until the operation finishes, then returns a result code.

Completion can be detected in two ways, chosen per request: bit 7 data polling or bit 6 toggle detection. A status read can land at the same moment the flash finishes, so a poll that looks complete is never trusted alone. The sequencer reads the location twice more and reports success only when both reads are fully valid. A programmable limit on polling time catches a flash that never finishes. When that limit trips, the sequencer writes the exit command before it reports.

Both the request port and the response port are valid/ready. A request is taken when `req_valid` and `req_ready` are high on the same edge. `req_ready` is high only while the sequencer is idle, so a request offered during an operation simply waits. A response stays on `rsp_valid` with stable contents until the host raises `rsp_ready`. Only after that handshake does the sequencer return to idle and accept another request.

Top module: `flash_op_seq`

## Requirements
- R1: `req_ready` is 1 only when no operation is in progress and no response is pending. A request offered while busy is not taken and causes no bus cycle.
- R2: A program request (`req_op`=0) writes, in order: 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x00A0, then `req_addr`/`req_data`.
- R3: An erase request writes 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x0080, 0x5555/0x00AA, 0x2AAA/0x0055, then a sixth write. For a sector erase (`req_op`=1) the sixth write is `req_addr`/0x0030. For a block erase (`req_op`=2) it is `req_addr`/0x0050. For a chip erase (`req_op`=3) it is 0x5555/0x0010.
- R4: In every command cycle the upper data byte (bits 15:8) is zero. The program data cycle is the only write that may have a non-zero upper byte.
- R5: No status read is issued before the final write of the sequence is acknowledged, and every status read addresses `req_addr`.
- R6: With `req_mode`=0 (data polling), a read is a completion when its bit 7 equals bit 7 of `req_data` for a program, or equals 1 for an erase.
- R7: With `req_mode`=1 (toggle), a read is a completion when its bit 6 equals bit 6 of the read just before it. The first status read can never be a completion.
- R8: After a completion, exactly two confirm reads follow. The result is code 0 only if both reads again meet the completion rule and return the whole expected word (`req_data` for a program, 0xFFFF for an erase). Otherwise the result is code 2, with no exit write.
- R9: If a status read completes without showing completion while the poll-cycle counter is at or above `cfg_tmo`, the sequencer writes 0x5555/0x00F0 and then reports code 1. A completion is always taken ahead of a timeout.
- R10: An ID request (`req_op`=4) writes 0x5555/0x00AA, 0x2AAA/0x0055, 0x5555/0x0090. It then reads addresses 0 and 1, writes 0x5555/0x00F0, and reports code 0 with `rsp_id` = {word at 0, word at 1}.
- R11: `bus_req` together with `bus_we`, `bus_addr` and `bus_wdata` holds steady until `bus_ack`. Read data is taken in the cycle where `bus_ack` is high.
- R12: `rsp_valid` holds with stable `rsp_code` and `rsp_id` until `rsp_ready` is high. It drops in the cycle after that handshake.
- R13: A request with `req_op` of 5 to 7 reports code 3 without any bus cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_tmo | input | TW (16) | Poll timeout limit in clock cycles |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Sequencer idle, request can be taken |
| req_op | input | 3 | 0 program, 1 sector erase, 2 block erase, 3 chip erase, 4 read ID |
| req_mode | input | 1 | 0 data polling, 1 toggle detection |
| req_addr | input | AW (21) | Target word, sector or block address |
| req_data | input | DW (16) | Word to program |
| rsp_valid | output | 1 | Result available |
| rsp_ready | input | 1 | Host takes the result |
| rsp_code | output | 2 | 0 ok, 1 timeout, 2 verify failure, 3 unknown request |
| rsp_id | output | 2*DW (32) | Identification words for a read-ID request |
| bus_req | output | 1 | Bus cycle requested |
| bus_ack | input | 1 | Bus cycle finished, read data valid |
| bus_we | output | 1 | 1 write, 0 read |
| bus_addr | output | AW (21) | Bus address |
| bus_wdata | output | DW (16) | Bus write data |
| bus_rdata | input | DW (16) | Bus read data |

## Verification
The assertions check, on every cycle, the properties that hold no matter which request is running. These are: bus fields stay stable while a cycle waits, command bytes have a zero upper half, no read comes before the final write, a held response does not change, a timeout result is always preceded by the exit write, an unknown request makes no bus traffic, and a success result only follows both confirm reads. Only the bench scenarios can show that the exact write order matches each request kind. They also show the number of status reads for each busy length and polling mode, how a corrupted final word turns into a verify failure, where the timeout boundary falls against a completing read, and the ID words returned. The bench does this by sweeping every erase/program kind against both polling modes and several busy lengths, and it adds a slower-acknowledging bus for some runs.

// File: rtl/flash_seq_pkg.sv
package flash_seq_pkg;

  // request kinds
  localparam logic [2:0] OP_PROG = 3'd0;
  localparam logic [2:0] OP_SECT = 3'd1;
  localparam logic [2:0] OP_BLK  = 3'd2;
  localparam logic [2:0] OP_CHIP = 3'd3;
  localparam logic [2:0] OP_ID   = 3'd4;

  // result codes
  localparam logic [1:0] RC_OK    = 2'd0;
  localparam logic [1:0] RC_TMO   = 2'd1;
  localparam logic [1:0] RC_VFY   = 2'd2;
  localparam logic [1:0] RC_BADOP = 2'd3;

  // unlock addresses and command bytes
  localparam logic [15:0] ADR_KEY1 = 16'h5555;
  localparam logic [15:0] ADR_KEY2 = 16'h2AAA;
  localparam logic [7:0]  K_KEY1   = 8'hAA;
  localparam logic [7:0]  K_KEY2   = 8'h55;
  localparam logic [7:0]  K_PROG   = 8'hA0;
  localparam logic [7:0]  K_ERASE  = 8'h80;
  localparam logic [7:0]  K_IDENT  = 8'h90;
  localparam logic [7:0]  K_SECT   = 8'h30;
  localparam logic [7:0]  K_BLK    = 8'h50;
  localparam logic [7:0]  K_CHIP   = 8'h10;
  localparam logic [7:0]  K_EXIT   = 8'hF0;

  typedef enum logic [2:0] {
    S_IDLE,
    S_WR,
    S_POLL,
    S_CONF,
    S_IDRD,
    S_EXIT,
    S_FIN
  } seq_state_e;

endpackage

// File: rtl/flash_seq_cmd.sv
// Command sequence table: gives the write for a request kind and step index.
module flash_seq_cmd
  import flash_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16
) (
  input  logic [2:0]    op,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          data_cycle,
  output logic          last
);

  always_comb begin
    wr_addr    = AW'(ADR_KEY1);
    wr_data    = DW'(K_KEY1);
    data_cycle = 1'b0;
    last       = 1'b0;
    case (step)
      3'd0: ;
      3'd1, 3'd4: begin
        wr_addr = AW'(ADR_KEY2);
        wr_data = DW'(K_KEY2);
      end
      3'd2: begin
        case (op)
          OP_PROG: wr_data = DW'(K_PROG);
          OP_ID: begin
            wr_data = DW'(K_IDENT);
            last    = 1'b1;
          end
          default: wr_data = DW'(K_ERASE);
        endcase
      end
      3'd3: begin
        if (op == OP_PROG) begin
          wr_addr    = tgt_addr;
          wr_data    = tgt_data;
          data_cycle = 1'b1;
          last       = 1'b1;
        end
      end
      3'd5: begin
        last = 1'b1;
        case (op)
          OP_SECT: begin
            wr_addr = tgt_addr;
            wr_data = DW'(K_SECT);
          end
          OP_BLK: begin
            wr_addr = tgt_addr;
            wr_data = DW'(K_BLK);
          end
          default: wr_data = DW'(K_CHIP);
        endcase
      end
      default: last = 1'b1;
    endcase
  end

endmodule

// File: rtl/flash_seq_poll.sv
// Status evaluation for one read: completion rule and full-word validity.
module flash_seq_poll #(
  parameter int DW = 16
) (
  input  logic [DW-1:0] rd,
  input  logic          toggle_mode,
  input  logic          is_prog,
  input  logic          first,
  input  logic          prev6,
  input  logic [DW-1:0] tgt_data,
  output logic          complete,
  output logic          valid
);

  logic [DW-1:0] expect_w;

  assign expect_w = is_prog ? tgt_data : '1;

  always_comb begin
    if (toggle_mode) complete = !first && (rd[6] == prev6);
    else             complete = (rd[7] == expect_w[7]);
    valid = complete && (rd == expect_w);
  end

endmodule

// File: rtl/flash_seq_tmo.sv
// Poll time budget: saturating cycle counter compared to a limit.
module flash_seq_tmo #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          en,
  input  logic [TW-1:0] limit,
  output logic          expired
);

  localparam logic [TW-1:0] CNT_MAX = '1;

  logic [TW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)                        cnt <= '0;
    else if (clr)                      cnt <= '0;
    else if (en && (cnt != CNT_MAX))   cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= limit);

  // R9: the budget never runs backwards unless cleared
  p_tmo_mono_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> (cnt >= $past(cnt)));

endmodule

// File: rtl/flash_op_seq.sv
module flash_op_seq
  import flash_seq_pkg::*;
#(
  parameter int AW = 21,
  parameter int DW = 16,
  parameter int TW = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [TW-1:0]   cfg_tmo,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [2:0]      req_op,
  input  logic            req_mode,
  input  logic [AW-1:0]   req_addr,
  input  logic [DW-1:0]   req_data,
  output logic            rsp_valid,
  input  logic            rsp_ready,
  output logic [1:0]      rsp_code,
  output logic [2*DW-1:0] rsp_id,
  output logic            bus_req,
  input  logic            bus_ack,
  output logic            bus_we,
  output logic [AW-1:0]   bus_addr,
  output logic [DW-1:0]   bus_wdata,
  input  logic [DW-1:0]   bus_rdata
);

  seq_state_e      state;
  logic [2:0]      op_q;
  logic [AW-1:0]   addr_q;
  logic [DW-1:0]   data_q;
  logic            mode_q;
  logic [2:0]      step_q;
  logic            first_q;
  logic            prev6_q;
  logic            conf_q;
  logic            bad_q;
  logic            idx_q;
  logic            final_q;
  logic            exit_q;
  logic [1:0]      code_q;
  logic [2*DW-1:0] id_q;

  logic [AW-1:0]   cmd_addr;
  logic [DW-1:0]   cmd_data;
  logic            cmd_data_cycle;
  logic            cmd_last;
  logic            p_complete;
  logic            p_valid;
  logic            tmo_exp;
  logic            tmo_clr;
  logic            tmo_en;

  flash_seq_cmd #(.AW(AW), .DW(DW)) u_cmd (
    .op         (op_q),
    .step       (step_q),
    .tgt_addr   (addr_q),
    .tgt_data   (data_q),
    .wr_addr    (cmd_addr),
    .wr_data    (cmd_data),
    .data_cycle (cmd_data_cycle),
    .last       (cmd_last)
  );

  flash_seq_poll #(.DW(DW)) u_poll (
    .rd          (bus_rdata),
    .toggle_mode (mode_q),
    .is_prog     (op_q == OP_PROG),
    .first       ((state == S_POLL) ? first_q : 1'b0),
    .prev6       (prev6_q),
    .tgt_data    (data_q),
    .complete    (p_complete),
    .valid       (p_valid)
  );

  assign tmo_clr = (state == S_WR) && bus_ack && cmd_last;
  assign tmo_en  = (state == S_POLL) || (state == S_CONF);

  flash_seq_tmo #(.TW(TW)) u_tmo (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (tmo_clr),
    .en      (tmo_en),
    .limit   (cfg_tmo),
    .expired (tmo_exp)
  );

  // bus master drive
  always_comb begin
    bus_req   = 1'b0;
    bus_we    = 1'b0;
    bus_addr  = addr_q;
    bus_wdata = '0;
    case (state)
      S_WR: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = cmd_addr;
        bus_wdata = cmd_data;
      end
      S_POLL, S_CONF: bus_req = 1'b1;
      S_IDRD: begin
        bus_req  = 1'b1;
        bus_addr = AW'(idx_q);
      end
      S_EXIT: begin
        bus_req   = 1'b1;
        bus_we    = 1'b1;
        bus_addr  = AW'(ADR_KEY1);
        bus_wdata = DW'(K_EXIT);
      end
      default: ;
    endcase
  end

  assign req_ready = (state == S_IDLE);
  assign rsp_valid = (state == S_FIN);
  assign rsp_code  = code_q;
  assign rsp_id    = id_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= S_IDLE;
      op_q    <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      mode_q  <= 1'b0;
      step_q  <= '0;
      first_q <= 1'b1;
      prev6_q <= 1'b0;
      conf_q  <= 1'b0;
      bad_q   <= 1'b0;
      idx_q   <= 1'b0;
      final_q <= 1'b0;
      exit_q  <= 1'b0;
      code_q  <= RC_OK;
      id_q    <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (req_valid) begin
            op_q    <= req_op;
            addr_q  <= req_addr;
            data_q  <= req_data;
            mode_q  <= req_mode;
            step_q  <= '0;
            first_q <= 1'b1;
            idx_q   <= 1'b0;
            final_q <= 1'b0;
            exit_q  <= 1'b0;
            conf_q  <= 1'b0;
            bad_q   <= 1'b0;
            id_q    <= '0;
            if (req_op > OP_ID) begin
              code_q <= RC_BADOP;
              state  <= S_FIN;
            end else begin
              code_q <= RC_OK;
              state  <= S_WR;
            end
          end
        end
        S_WR: begin
          if (bus_ack) begin
            if (cmd_last) begin
              final_q <= 1'b1;
              state   <= (op_q == OP_ID) ? S_IDRD : S_POLL;
            end else begin
              step_q <= step_q + 3'd1;
            end
          end
        end
        S_POLL: begin
          if (bus_ack) begin
            prev6_q <= bus_rdata[6];
            first_q <= 1'b0;
            if (p_complete) begin
              conf_q <= 1'b0;
              bad_q  <= 1'b0;
              state  <= S_CONF;
            end else if (tmo_exp) begin
              code_q <= RC_TMO;
              state  <= S_EXIT;
            end
          end
        end
        S_CONF: begin
          if (bus_ack) begin
            prev6_q <= bus_rdata[6];
            if (!p_valid) bad_q <= 1'b1;
            if (conf_q) begin
              code_q <= (bad_q || !p_valid) ? RC_VFY : RC_OK;
              state  <= S_FIN;
            end else begin
              conf_q <= 1'b1;
            end
          end
        end
        S_IDRD: begin
          if (bus_ack) begin
            if (!idx_q) begin
              id_q[2*DW-1:DW] <= bus_rdata;
              idx_q           <= 1'b1;
            end else begin
              id_q[DW-1:0] <= bus_rdata;
              state        <= S_EXIT;
            end
          end
        end
        S_EXIT: begin
          if (bus_ack) begin
            exit_q <= 1'b1;
            state  <= S_FIN;
          end
        end
        S_FIN: begin
          if (rsp_ready) state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R11: a waiting bus cycle keeps its fields
  p_bus_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_ack |=> bus_req && $stable(bus_we) && $stable(bus_addr) && $stable(bus_wdata));

  // R1: taking requests only while the bus and response port are quiet
  p_idle_only_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !bus_req && !rsp_valid);

  // R4: command bytes carry a zero upper half
  p_upper_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && bus_we && !((state == S_WR) && cmd_data_cycle) |-> bus_wdata[DW-1:8] == '0);

  // R5: no read before the final write has been acknowledged
  p_poll_after_final_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && !bus_we |-> final_q);

  // R12: a pending response stays put
  p_rsp_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_code) && $stable(rsp_id));

  // R9: a timeout result always follows the exit write
  p_tmo_exit_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_code == RC_TMO) |-> exit_q);

  // R13: an unknown request makes no bus traffic
  p_badop_quiet_r13: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_code == RC_BADOP) |-> !final_q && !exit_q);

  // R8: success on a program or erase needs both confirm reads
  p_conf_two_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_code == RC_OK) && (op_q != OP_ID) |-> conf_q);

endmodule

// File: tb/sim_flash_op_seq.sv
module sim_flash_op_seq;

  localparam logic [20:0] U1 = 21'h05555;
  localparam logic [20:0] U2 = 21'h02AAA;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_tmo = 16'hFFFF;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [2:0]  req_op = 3'd0;
  logic        req_mode = 1'b0;
  logic [20:0] req_addr = '0;
  logic [15:0] req_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [1:0]  rsp_code;
  logic [31:0] rsp_id;
  logic        bus_req;
  logic        bus_ack = 1'b0;
  logic        bus_we;
  logic [20:0] bus_addr;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata = '0;

  int total = 0;
  int bad = 0;

  always #5 clk = ~clk;

  flash_op_seq u0 (
    .clk(clk), .rst_n(rst_n), .cfg_tmo(cfg_tmo),
    .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
    .req_mode(req_mode), .req_addr(req_addr), .req_data(req_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_code(rsp_code), .rsp_id(rsp_id),
    .bus_req(bus_req), .bus_ack(bus_ack), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  // ---------------- flash bus model ----------------
  logic        m_clr = 1'b0;
  int          m_busy = 0;
  int          m_lat = 0;
  int          m_nw = 0;
  logic        m_b7 = 1'b0;
  logic [15:0] m_final = '0;
  logic [20:0] m_ra = '0;

  logic [36:0] wlog [16];
  int          wcnt = 0, rcnt = 0, busy_left = 0, wt = 0;
  int          hold_err = 0, early = 0, addr_err = 0;
  logic        tog = 1'b0, idm = 1'b0;
  logic [20:0] seen_a = '0;
  logic [15:0] seen_d = '0;
  logic        seen_we = 1'b0;

  always @(posedge clk) begin
    bus_ack <= 1'b0;
    if (m_clr) begin
      wcnt = 0; rcnt = 0; busy_left = m_busy; tog = 1'b0; idm = 1'b0;
      hold_err = 0; early = 0; addr_err = 0; wt = 0;
    end else if (bus_req && !bus_ack) begin
      if (wt == 0) begin
        seen_a = bus_addr; seen_d = bus_wdata; seen_we = bus_we;
      end else if (bus_addr !== seen_a || bus_wdata !== seen_d || bus_we !== seen_we) begin
        hold_err++;
      end
      if (wt < m_lat) wt++;
      else begin
        wt = 0;
        bus_ack <= 1'b1;
        if (bus_we) begin
          if (wcnt < 16) wlog[wcnt] = {bus_addr, bus_wdata};
          wcnt++;
          if (bus_wdata == 16'h0090) idm = 1'b1;
          if (bus_wdata == 16'h00F0) idm = 1'b0;
        end else begin
          rcnt++;
          if (wcnt < m_nw) early++;
          if (busy_left > 0) begin
            bus_rdata <= {8'h00, m_b7, tog, 6'h00};
            tog = ~tog;
            busy_left--;
            if (bus_addr !== m_ra) addr_err++;
          end else if (idm) begin
            bus_rdata <= (bus_addr == 21'd0) ? 16'h1234 : 16'h5678;
          end else begin
            bus_rdata <= m_final;
            if (bus_addr !== m_ra) addr_err++;
          end
        end
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input bit ok, input string rq, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", rq, what, act, exp);
    end
  endtask

  function automatic int nwr(input logic [2:0] op);
    if (op == 3'd0 || op == 3'd4) return 4;
    if (op > 3'd4) return 0;
    return 6;
  endfunction

  function automatic logic [36:0] exp_wr(input logic [2:0] op, input logic [20:0] a,
                                         input logic [15:0] d, input int i);
    case (i)
      0: return {U1, 16'h00AA};
      1: return {U2, 16'h0055};
      2: return {U1, (op == 3'd0) ? 16'h00A0 : (op == 3'd4) ? 16'h0090 : 16'h0080};
      3: return (op == 3'd0) ? {a, d} : (op == 3'd4) ? {U1, 16'h00F0} : {U1, 16'h00AA};
      4: return {U2, 16'h0055};
      5: return (op == 3'd1) ? {a, 16'h0030} : (op == 3'd2) ? {a, 16'h0050} : {U1, 16'h0010};
      default: return {U1, 16'h00F0};
    endcase
  endfunction

  function automatic int exp_reads(input logic mode, input int b, input logic f6);
    if (!mode) return b + 3;
    if (b == 0) return 4;
    return (f6 == logic'((b - 1) % 2)) ? b + 3 : b + 4;
  endfunction

  task automatic check_writes(input string rq, input logic [2:0] op, input logic [20:0] a,
                              input logic [15:0] d, input bit with_exit);
    int n = nwr(op);
    int tot = n + (with_exit ? 1 : 0);
    bit ok = (wcnt == tot);
    int upper = 0;
    chk(wcnt == tot, rq, "write count", wcnt, tot);
    for (int i = 0; i < n && ok; i++) begin
      if (wlog[i] !== exp_wr(op, a, d, i)) begin
        chk(0, rq, $sformatf("write %0d", i), wlog[i], exp_wr(op, a, d, i));
        ok = 0;
      end
    end
    if (ok && with_exit) chk(wlog[n] === {U1, 16'h00F0}, "R9", "exit write", wlog[n], {U1, 16'h00F0});
    for (int i = 0; i < tot && i < 16; i++)
      if (!(op == 3'd0 && i == 3) && wlog[i][15:8] != 8'h00) upper++;
    chk(upper == 0, "R4", "upper byte in command cycles", upper, 0);
  endtask

  task automatic run_op(input logic [2:0] op, input logic mode, input logic [20:0] a,
                        input logic [15:0] d, input int b, input logic [15:0] fin,
                        input logic [15:0] lim, input int hold, input int lat, input bit poke,
                        output logic [1:0] code, output logic [31:0] idv);
    int n = 0;
    logic [1:0] c0;
    @(negedge clk);
    m_busy = b; m_lat = lat; m_nw = nwr(op); m_ra = a;
    m_b7 = (op == 3'd0) ? ~d[7] : 1'b0;
    m_final = fin; cfg_tmo = lim; m_clr = 1'b1;
    @(negedge clk);
    m_clr = 1'b0;
    chk(req_ready === 1'b1, "R1", "ready while idle", req_ready, 1);
    req_op = op; req_mode = mode; req_addr = a; req_data = d; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    while (rsp_valid !== 1'b1 && n < 20000) begin
      if (n == 2) chk(req_ready === 1'b0, "R1", "ready while busy", req_ready, 0);
      if (poke) begin
        req_valid = (n >= 2);
        req_op = 3'd3;
      end
      @(negedge clk);
      n++;
    end
    req_valid = 1'b0;
    if (n >= 20000) chk(0, "WD", "response never came", n, 0);
    c0 = rsp_code;
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk(rsp_valid === 1'b1 && rsp_code === c0, "R12", "held response", {rsp_valid, rsp_code}, {1'b1, c0});
    end
    code = rsp_code;
    idv = rsp_id;
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(rsp_valid === 1'b0, "R12", "valid drops after handshake", rsp_valid, 0);
    chk(hold_err == 0, "R11", "bus fields stable while waiting", hold_err, 0);
  endtask

  // ---------------- stimulus ----------------
  initial begin
    logic [1:0]  code;
    logic [31:0] idv;
    logic [15:0] d, expw;
    logic [20:0] a;

    repeat (4) @(negedge clk);
    chk(req_ready === 1'b0 || rst_n === 1'b0, "R1", "reset held", req_ready, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(req_ready === 1'b1 && bus_req === 1'b0 && rsp_valid === 1'b0, "R1",
        "reset state", {req_ready, bus_req, rsp_valid}, 3'b100);

    // sweep: request kind x polling mode x busy length
    for (int op = 0; op < 4; op++) begin
      for (int md = 0; md < 2; md++) begin
        for (int b = 0; b < 4; b++) begin
          a = 21'h10A00 + 21'(op * 21'h0800) + 21'(b * 3);
          d = 16'h4A21 ^ (16'(b) << 7) ^ (16'(op) << 4) ^ (16'(md) << 6);
          expw = (op == 0) ? d : 16'hFFFF;
          run_op(3'(op), logic'(md), a, d, b, expw, 16'hFFFF, 0, (b == 3) ? 2 : 0, 1'b0, code, idv);
          chk(code == 2'd0, md ? "R7" : "R6", $sformatf("code op%0d b%0d", op, b), code, 0);
          check_writes((op == 0) ? "R2" : "R3", 3'(op), a, d, 1'b0);
          chk(rcnt == exp_reads(logic'(md), b, expw[6]), md ? "R7" : "R6",
              $sformatf("read count op%0d b%0d", op, b), rcnt, exp_reads(logic'(md), b, expw[6]));
          chk(early == 0 && addr_err == 0, "R5", "status read timing and address",
              {early, addr_err}, 0);
        end
      end
    end

    // R8: final word wrong on the confirm reads
    for (int op = 0; op < 2; op++) begin
      for (int md = 0; md < 2; md++) begin
        a = 21'h03300 + 21'(op);
        d = 16'h00C3;
        expw = (op == 0) ? d : 16'hFFFF;
        run_op(3'(op), logic'(md), a, d, 1, expw ^ 16'h0100, 16'hFFFF, 0, 0, 1'b0, code, idv);
        chk(code == 2'd2, "R8", $sformatf("verify failure op%0d mode%0d", op, md), code, 2);
        chk(wcnt == nwr(3'(op)), "R8", "no exit write on verify failure", wcnt, nwr(3'(op)));
      end
    end

    // R9: operation that never finishes
    run_op(3'd0, 1'b0, 21'h00444, 16'h1155, 1000, 16'h1155, 16'd20, 0, 0, 1'b0, code, idv);
    chk(code == 2'd1, "R9", "timeout code data mode", code, 1);
    check_writes("R9", 3'd0, 21'h00444, 16'h1155, 1'b1);
    run_op(3'd1, 1'b1, 21'h12800, 16'h0000, 1000, 16'hFFFF, 16'd20, 0, 0, 1'b0, code, idv);
    chk(code == 2'd1, "R9", "timeout code toggle mode", code, 1);
    check_writes("R9", 3'd1, 21'h12800, 16'h0000, 1'b1);

    // R9 boundary: zero budget, completion wins on the first read
    run_op(3'd0, 1'b0, 21'h00020, 16'h0081, 0, 16'h0081, 16'd0, 0, 0, 1'b0, code, idv);
    chk(code == 2'd0, "R9", "completion ahead of zero budget", code, 0);
    run_op(3'd0, 1'b0, 21'h00021, 16'h0081, 1, 16'h0081, 16'd0, 0, 0, 1'b0, code, idv);
    chk(code == 2'd1, "R9", "zero budget busy read", code, 1);
    chk(rcnt == 1, "R9", "single read before exit", rcnt, 1);

    // R10: identification
    run_op(3'd4, 1'b0, 21'h0, 16'h0, 0, 16'h0, 16'hFFFF, 0, 1, 1'b0, code, idv);
    chk(code == 2'd0, "R10", "id code", code, 0);
    chk(idv == 32'h12345678, "R10", "id words", idv, 32'h12345678);
    check_writes("R10", 3'd4, 21'h0, 16'h0, 1'b0);
    chk(rcnt == 2, "R10", "id reads", rcnt, 2);

    // R13: unknown request kinds
    for (int op = 5; op < 8; op++) begin
      run_op(3'(op), 1'b0, 21'h0, 16'h0, 0, 16'h0, 16'hFFFF, 0, 0, 1'b0, code, idv);
      chk(code == 2'd3, "R13", $sformatf("bad op %0d code", op), code, 3);
      chk(wcnt == 0 && rcnt == 0, "R13", "no bus cycles", wcnt + rcnt, 0);
    end

    // R12: response back-pressure
    run_op(3'd2, 1'b0, 21'h18000, 16'h0, 2, 16'hFFFF, 16'hFFFF, 6, 0, 1'b0, code, idv);
    chk(code == 2'd0, "R12", "code after back-pressure", code, 0);

    // R1: request offered during an operation is ignored
    run_op(3'd0, 1'b1, 21'h00777, 16'h3322, 3, 16'h3322, 16'hFFFF, 0, 0, 1'b1, code, idv);
    chk(code == 2'd0, "R1", "code with request poked while busy", code, 0);
    check_writes("R1", 3'd0, 21'h00777, 16'h3322, 1'b0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(bus_req === 1'b0 && req_ready === 1'b1, "R1", "no new operation afterwards",
          {bus_req, req_ready}, 2'b01);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule